// File: doc/BRIEF.md
# 100BASE-X PCS Transmit Code-Group Encoder

This block sits between the MII transmit side of a MAC and the serializer of a 100 Mb/s physical layer. On every edge of the 25 MHz transmit clock it samples one data nibble together with the transmit-enable and transmit-error strobes. It then registers one 5-bit code group for the serializer.

Between frames it sends continuous Idle code groups. When a frame begins, the first preamble octet is replaced by the start-of-stream delimiter J/K. Every later nibble is mapped through the 4B/5B data table. When transmit-enable falls, the end-of-stream delimiter T/R is appended and Idle resumes.

A transmit error inside a frame turns that nibble into a Halt code group. When the test control is set, the error instead produces a deliberately invalid code group, so the receive path of a link partner can be exercised.

Top module: `pcs_tx_encoder`

## Requirements
- R1: While reset is low, and on every clock after it until a frame starts, `tx_code` is Idle (11111).
- R2: While no frame is active and `tx_en` is sampled low, `tx_code` stays Idle, whatever `tx_er` and `txd` do.
- R3: The first clock edge on which `tx_en` is sampled high while idle makes `tx_code` J (11000) right after that edge. The next edge gives K (10001). The `txd` and `tx_er` values of those two nibbles have no effect.
- R4: Each later nibble sampled with `tx_en` high and `tx_er` low appears one clock later as its 4B/5B data code: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R5: The first edge with `tx_en` low after a frame has started gives T (01101). The next edge gives R (00111). Idle follows. This also holds when `tx_en` drops directly after the two delimiter nibbles, which gives J, K, T, R.
- R6: A data nibble sampled with `tx_er` high and `inv_test` low is sent as Halt (00100).
- R7: A data nibble sampled with `tx_er` high and `inv_test` high is sent as an invalid code group. List the 32 five-bit values in ascending order and remove the 16 data codes and J, K, T, R, Idle and Halt. The ten values left are indexed 0 to 9, and `txd` picks that entry. A `txd` of 10 to 15 gives 00000.
- R8: A new frame may start on the edge right after R has been emitted. `tx_en` first sampled high on that edge gives J on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame active strobe from the MAC |
| tx_er | input | 1 | Transmit error strobe from the MAC |
| txd | input | 4 | Transmit data nibble |
| inv_test | input | 1 | Test control: errors emit invalid code groups instead of Halt |
| tx_code | output | 5 | Registered 5-bit code group to the serializer |

## Verification
The data path is driven with a frame whose payload walks all sixteen nibble values. This separates every 4B/5B table entry and shows the one-clock placement of J and K. Error strobes are driven in several places: between frames, on the delimiter nibbles, and inside the payload. This tells the Halt path from the invalid-code path and shows where the error strobe is ignored. Every `txd` value is swept with the test control set, so the index into the invalid list and its wrap to 00000 are both covered. Frames that end right after K, and frames that start on the first edge after R, separate the delimiter sequencing from the ordinary data flow.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;

  localparam int NIB_W  = 4;
  localparam int SYM_W  = 5;
  localparam int N_NIB  = 1 << NIB_W;
  localparam int N_SYM  = 1 << SYM_W;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;
  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_HALT = 5'b00100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SSD2 = 2'd1,
    ST_DATA = 2'd2,
    ST_ESD2 = 2'd3
  } tx_st_e;

  // 4B/5B data mapping
  function automatic sym_t enc_4b5b(input nib_t n);
    sym_t s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // True for any code group with a defined meaning (data or control)
  function automatic logic is_legal(input sym_t s);
    logic hit;
    hit = (s == SYM_J) || (s == SYM_K) || (s == SYM_T) ||
          (s == SYM_R) || (s == SYM_IDLE) || (s == SYM_HALT);
    for (int i = 0; i < N_NIB; i++) begin
      if (enc_4b5b(nib_t'(i)) == s) hit = 1'b1;
    end
    return hit;
  endfunction

  // The sel-th undefined code group in ascending order; 0 past the end
  function automatic sym_t bad_sym(input nib_t sel);
    sym_t res;
    int   cnt;
    res = '0;
    cnt = 0;
    for (int v = 0; v < N_SYM; v++) begin
      if (!is_legal(sym_t'(v))) begin
        if (cnt == int'(sel)) res = sym_t'(v);
        cnt = cnt + 1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/pcs_tx_ctrl.sv
module pcs_tx_ctrl
  import pcs_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tx_en,
  output tx_st_e cur_st
);

  tx_st_e nxt_st;

  always_comb begin
    nxt_st = cur_st;
    case (cur_st)
      ST_IDLE: if (tx_en) nxt_st = ST_SSD2;
      ST_SSD2: nxt_st = ST_DATA;
      ST_DATA: if (!tx_en) nxt_st = ST_ESD2;
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_st <= ST_IDLE;
    else        cur_st <= nxt_st;
  end

endmodule

// File: rtl/pcs_tx_symsel.sv
module pcs_tx_symsel
  import pcs_tx_pkg::*;
(
  input  tx_st_e cur_st,
  input  logic   tx_en,
  input  logic   tx_er,
  input  logic   inv_test,
  input  nib_t   txd,
  output sym_t   nxt_sym
);

  sym_t data_sym;
  sym_t err_sym;

  always_comb begin
    data_sym = enc_4b5b(txd);
    err_sym  = inv_test ? bad_sym(txd) : SYM_HALT;
  end

  always_comb begin
    case (cur_st)
      ST_IDLE: nxt_sym = tx_en ? SYM_J : SYM_IDLE;
      ST_SSD2: nxt_sym = SYM_K;
      ST_DATA: begin
        if (!tx_en)     nxt_sym = SYM_T;
        else if (tx_er) nxt_sym = err_sym;
        else            nxt_sym = data_sym;
      end
      default: nxt_sym = SYM_R;
    endcase
  end

endmodule

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
  import pcs_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  input  logic             inv_test,
  output logic [SYM_W-1:0] tx_code
);

  tx_st_e cur_st;
  sym_t   nxt_sym;

  pcs_tx_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .cur_st (cur_st)
  );

  pcs_tx_symsel i_symsel (
    .cur_st   (cur_st),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .inv_test (inv_test),
    .txd      (txd),
    .nxt_sym  (nxt_sym)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_code <= SYM_IDLE;
    else        tx_code <= nxt_sym;
  end

endmodule

// File: rtl/pcs_tx_chk.sv
module pcs_tx_chk
  import pcs_tx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_er,
  input logic [NIB_W-1:0] txd,
  input logic             inv_test,
  input logic [SYM_W-1:0] tx_code,
  input tx_st_e           cur_st
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> tx_code == SYM_IDLE);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_IDLE && !tx_en) |=> tx_code == SYM_IDLE);

  assert_start_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_IDLE && tx_en) |=> tx_code == SYM_J);

  assert_j_then_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == SYM_J) |=> tx_code == SYM_K);

  assert_data_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_DATA && tx_en && !tx_er) |=> tx_code == enc_4b5b($past(txd)));

  assert_t_then_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == SYM_T) |=> tx_code == SYM_R);

  assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_DATA && tx_en && tx_er && !inv_test) |=> tx_code == SYM_HALT);

  assert_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_DATA && tx_en && tx_er && inv_test) |=> !is_legal(tx_code));

  assert_after_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == SYM_R) |=> (tx_code == SYM_IDLE || tx_code == SYM_J));

endmodule

bind pcs_tx_encoder pcs_tx_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .tx_er    (tx_er),
  .txd      (txd),
  .inv_test (inv_test),
  .tx_code  (tx_code),
  .cur_st   (cur_st)
);

// File: tb/test_pcs_tx_encoder.sv
module test_pcs_tx_encoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       inv_test = 1'b0;
  logic [4:0] tx_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  logic [4:0] bad_tab [16];
  int         m_st = 0;

  always #5 clk = ~clk;

  pcs_tx_encoder i_pcs_tx_encoder (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
    .txd(txd), .inv_test(inv_test), .tx_code(tx_code)
  );

  function automatic logic [4:0] dcode(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  // Undefined code groups: everything not data and not J K T R Idle Halt
  task automatic build_bad();
    bit used [32];
    int k;
    for (int i = 0; i < 32; i++) used[i] = 0;
    for (int i = 0; i < 16; i++) used[dcode(4'(i))] = 1;
    used[5'b11000] = 1; used[5'b10001] = 1; used[5'b01101] = 1;
    used[5'b00111] = 1; used[5'b11111] = 1; used[5'b00100] = 1;
    for (int i = 0; i < 16; i++) bad_tab[i] = 5'b00000;
    k = 0;
    for (int v = 0; v < 32; v++) begin
      if (!used[v]) begin
        bad_tab[k] = 5'(v);
        k++;
      end
    end
  endtask

  // Drive one nibble and predict the code group after the next edge
  task automatic drive(input logic en, input logic er, input logic [3:0] d,
                       input logic tst, input string tag);
    logic [4:0] e;
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d; inv_test = tst;
    case (m_st)
      0: if (en) begin e = 5'b11000; m_st = 1; end else e = 5'b11111;
      1: begin e = 5'b10001; m_st = 2; end
      2: begin
        if (!en) begin e = 5'b01101; m_st = 3; end
        else if (er) e = tst ? bad_tab[d] : 5'b00100;
        else e = dcode(d);
      end
      default: begin e = 5'b00111; m_st = 0; end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Monitor: compare one prediction per clock edge
  initial begin
    logic [4:0] e;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (tx_code !== e) begin
          fails++;
          $display("FAIL %s: tx_code=%b expected=%b", t, tx_code, e);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    build_bad();
    // R1: idle during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (tx_code !== 5'b11111) begin
      fails++;
      $display("FAIL R1: tx_code=%b expected=%b", tx_code, 5'b11111);
    end
    rst_n = 1'b1;
    drive(0, 0, 4'h0, 0, "R1");
    drive(0, 0, 4'h0, 0, "R1");
    // R2: error strobe and data while idle have no effect
    drive(0, 1, 4'h3, 0, "R2");
    drive(0, 1, 4'hC, 1, "R2");
    drive(0, 0, 4'h7, 0, "R2");
    // R3 + R4: errors on the delimiter nibbles are ignored, payload 0..F
    drive(1, 1, 4'h5, 0, "R3");
    drive(1, 1, 4'h5, 1, "R3");
    for (int i = 0; i < 16; i++) drive(1, 0, 4'(i), 0, "R4");
    // R5: end-of-stream delimiter
    drive(0, 0, 4'h0, 0, "R5");
    drive(0, 0, 4'h0, 0, "R5");
    drive(0, 0, 4'h0, 0, "R5");
    // R6: Halt on error with the test control clear
    drive(1, 0, 4'h5, 0, "R3");
    drive(1, 0, 4'h5, 0, "R3");
    drive(1, 0, 4'hA, 0, "R4");
    drive(1, 1, 4'hA, 0, "R6");
    drive(1, 1, 4'h0, 0, "R6");
    drive(1, 0, 4'h2, 0, "R4");
    drive(0, 0, 4'h0, 0, "R5");
    drive(0, 0, 4'h0, 0, "R5");
    // R8: restart on the edge right after R
    drive(1, 0, 4'h5, 1, "R8");
    drive(1, 0, 4'h5, 1, "R3");
    // R7: sweep every nibble with error and test control set
    for (int i = 0; i < 16; i++) drive(1, 1, 4'(i), 1, "R7");
    drive(1, 0, 4'h9, 1, "R4");
    drive(0, 0, 4'h0, 1, "R5");
    drive(0, 0, 4'h0, 1, "R5");
    // R5 + R8: shortest frame J K T R, started right after R
    drive(1, 0, 4'h5, 0, "R8");
    drive(1, 0, 4'h5, 0, "R3");
    drive(0, 0, 4'h0, 0, "R5");
    drive(0, 0, 4'h0, 0, "R5");
    drive(0, 1, 4'h1, 0, "R2");
    drive(0, 0, 4'h0, 0, "R2");
    wait (exp_q.size() == 0);
    @(posedge clk);
    #3;
    done = 1;
    summary();
    $finish;
  end

endmodule